// File: doc/BRIEF.md
# Dynamic Phase Shift Step Controller

This block moves the output phase of a clock manager in single fine steps. A request names a step count and a direction. The block answers with an acknowledge and holds it until the requester drops the request. Only then does it begin shifting. Each step is one enable pulse to the clock manager's phase-shift port, followed by a wait for that manager's single-cycle done pulse. The next step does not start until the done pulse for the current step has arrived.

The block keeps a signed count of the steps that have completed, and this count can be read at any time. A shift sequence is abandoned, and an error flag is raised, in three cases: the clock manager loses lock, it reports that the shift range is used up, or it does not answer a step within a fixed number of cycles. All logic runs on the phase-shift clock.

Top module: `phase_step_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, and after it, `ack`, `ps_en`, `ps_incdec`, `busy` and `err` are 0 and `offset` is 0.
- R2: When idle, a request sampled high at a clock edge latches `req_steps` and `req_sign` and raises `ack` from the next cycle. `ack` stays high while `req` remains high.
- R3: No enable pulse is issued while the request is still high. The first `ps_en` appears in the cycle after the edge at which `req` is sampled low, provided the step count is non-zero and `locked` is 1.
- R4: `ps_en` is high for exactly one cycle per step. In that cycle `ps_incdec` equals the latched sign, with 1 meaning increment and 0 meaning decrement.
- R5: After each enable, the next enable is issued only in the cycle after a `ps_done` pulse is sampled. Exactly as many enables are issued as were requested, unless the sequence is aborted.
- R6: Each `ps_done` pulse that arrives while waiting, with `locked` high and `ps_ovf` low, changes `offset` by +1 (increment) or -1 (decrement) from the next cycle. `offset` changes at no other time.
- R7: A request with a step count of 0 is acknowledged, but it produces no enable and leaves `err` at 0.
- R8: No enable is issued while `locked` is 0. If `locked` is 0 when a step is due, or while a step is waiting for done, the sequence ends, `busy` falls and `err` is set.
- R9: If `ps_ovf` is 1 in the cycle of a `ps_done` pulse, the remaining steps are abandoned, `offset` is left unchanged, `err` is set and the block returns to idle.
- R10: If no `ps_done` arrives within TMO_CYCLES (default 1024) cycles after an enable, `err` is set and the block returns to idle.
- R11: `busy` is high from the acknowledge until the sequence ends. `err` stays set until the next request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Shift request, four-phase handshake |
| req_steps | input | CNT_W | Number of steps requested |
| req_sign | input | 1 | Direction: 1 increment, 0 decrement |
| ack | output | 1 | Request acknowledged, held until req drops |
| ps_en | output | 1 | One-cycle phase-shift enable per step |
| ps_incdec | output | 1 | Step direction presented with ps_en |
| ps_done | input | 1 | One-cycle step-complete pulse from clock manager |
| locked | input | 1 | Clock manager lock status |
| ps_ovf | input | 1 | Clock manager shift-range limit status |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last sequence aborted |
| offset | output | OFS_W | Signed count of completed steps |

## Verification
`ack` is due one cycle after the edge at which the request is sampled. The first `ps_en` is due one cycle after the edge at which the request is sampled low. Every later `ps_en` is due one cycle after a sampled done pulse. `offset`, `err` and the fall of `busy` are due one cycle after the done pulse, abort condition or timeout edge that causes them. A behavioural reference model advances on each rising edge from the same sampled inputs. The clock-manager model and the stimulus change their signals just after the rising edge. All outputs are compared against the model at the falling edge, so each result is checked in the exact cycle it is due. Directed checks after each scenario compare `offset` and `err` against values worked out by hand from the step counts and the shift-range limit.

// File: rtl/phase_step_pkg.sv
// Package: shared state encoding for the phase step controller.
// Assumes: used by all phase_step modules in one clock domain.
package phase_step_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } pstep_state_t;
endpackage

// File: rtl/pstep_timer.sv
// Module: per-step response timer. Counts cycles while run is high and
// flags expiry on the last allowed cycle.
// Assumes: clear is high whenever the controller is not waiting for done.
module pstep_timer #(
    parameter int TMO_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(TMO_CYCLES - 1);

    logic [TW-1:0] count;

    // Count wait cycles; restart whenever a new wait begins.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (run && count != LAST) count <= count + 1'b1;
    end

    assign expired = run && (count == LAST);

    // The counter never moves past the last allowed value.
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == LAST) |=> (count == LAST || count == '0)); // R10
endmodule

// File: rtl/pstep_offset.sv
// Module: signed accumulator of completed phase steps.
// Assumes: upd is high for one cycle per completed step.
module pstep_offset #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             dir_up,
    output logic [OFS_W-1:0] offset
);
    // Add or subtract one on each completed step.
    always_ff @(posedge clk) begin
        if (!rst_n)      offset <= '0;
        else if (upd)    offset <= dir_up ? offset + 1'b1 : offset - 1'b1;
    end

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(offset)); // R6
endmodule

// File: rtl/pstep_fsm.sv
// Module: request handshake and step sequencing for the phase shift port.
// Assumes: ps_done is a one-cycle pulse; ps_ovf is valid in the done cycle;
// all inputs are synchronous to clk.
module pstep_fsm
    import phase_step_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] req_steps,
    input  logic             req_sign,
    input  logic             ps_done,
    input  logic             locked,
    input  logic             ps_ovf,
    input  logic             tmo_expired,
    output logic             ack,
    output logic             ps_en,
    output logic             ps_incdec,
    output logic             busy,
    output logic             err,
    output logic             step_done,
    output logic             waiting
);
    pstep_state_t     state;
    logic [CNT_W-1:0] remain;
    logic             sign_q;
    logic             err_q;

    // Sequence the handshake, step issue and done wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            sign_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    remain <= req_steps;
                    sign_q <= req_sign;
                    err_q  <= 1'b0;
                    state  <= ST_ACK;
                end
                ST_ACK: if (!req) begin
                    if (remain == '0) state <= ST_IDLE;
                    else if (!locked) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (locked) state <= ST_WAIT;
                    else begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (!locked) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else if (ps_done) begin
                        if (ps_ovf) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else if (remain == CNT_W'(1)) begin
                            remain <= '0;
                            state  <= ST_IDLE;
                        end else begin
                            remain <= remain - 1'b1;
                            state  <= ST_ISSUE;
                        end
                    end else if (tmo_expired) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode outputs from the current state.
    always_comb begin
        ack       = (state == ST_ACK);
        ps_en     = (state == ST_ISSUE) && locked;
        ps_incdec = sign_q;
        busy      = (state != ST_IDLE);
        err       = err_q;
        waiting   = (state == ST_WAIT);
        step_done = waiting && locked && ps_done && !ps_ovf;
    end

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ps_en |=> !ps_en); // R4
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> ack); // R2
    AST_NO_EN_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> !ps_en); // R3
    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_en && $past(busy)) |-> $stable(ps_incdec)); // R4
    AST_OVF_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && locked && ps_done && ps_ovf) |=> (!busy && err)); // R9
    AST_LOCK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !locked) |=> (!busy && err)); // R8
endmodule

// File: rtl/phase_step_ctrl.sv
// Module: top of the dynamic phase shift step controller. Joins the
// sequencer, the per-step timeout and the offset accumulator.
// Assumes: one clock (the phase-shift clock) for all ports.
module phase_step_ctrl #(
    parameter int CNT_W      = 8,
    parameter int OFS_W      = 16,
    parameter int TMO_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] req_steps,
    input  logic             req_sign,
    output logic             ack,
    output logic             ps_en,
    output logic             ps_incdec,
    input  logic             ps_done,
    input  logic             locked,
    input  logic             ps_ovf,
    output logic             busy,
    output logic             err,
    output logic [OFS_W-1:0] offset
);
    logic tmo_expired;
    logic step_done;
    logic waiting;

    pstep_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_steps   (req_steps),
        .req_sign    (req_sign),
        .ps_done     (ps_done),
        .locked      (locked),
        .ps_ovf      (ps_ovf),
        .tmo_expired (tmo_expired),
        .ack         (ack),
        .ps_en       (ps_en),
        .ps_incdec   (ps_incdec),
        .busy        (busy),
        .err         (err),
        .step_done   (step_done),
        .waiting     (waiting)
    );

    pstep_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!waiting),
        .run     (waiting),
        .expired (tmo_expired)
    );

    pstep_offset #(.OFS_W(OFS_W)) u_offset (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (step_done),
        .dir_up (ps_incdec),
        .offset (offset)
    );
endmodule

// File: tb/phase_step_ctrl_test.sv
// Bench: behavioural reference model compared at every falling edge, plus
// a simple clock manager model answering enables with done pulses.
module phase_step_ctrl_test;
    localparam int CNT_W = 8;
    localparam int OFS_W = 16;
    localparam int TMO   = 1024;
    localparam int LIM   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [CNT_W-1:0] req_steps = '0;
    logic req_sign = 1'b0;
    logic ack, ps_en, ps_incdec, busy, err;
    logic ps_done = 1'b0;
    logic locked = 1'b1;
    logic ps_ovf = 1'b0;
    logic [OFS_W-1:0] offset;

    always #5 clk = ~clk;

    phase_step_ctrl #(.CNT_W(CNT_W), .OFS_W(OFS_W), .TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_steps(req_steps),
        .req_sign(req_sign), .ack(ack), .ps_en(ps_en), .ps_incdec(ps_incdec),
        .ps_done(ps_done), .locked(locked), .ps_ovf(ps_ovf), .busy(busy),
        .err(err), .offset(offset)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model: mode 0 idle, 1 acknowledging, 2 step due, 3 waiting.
    int m_mode = 0, m_left = 0, m_tcnt = 0, m_ofs = 0;
    bit m_sign = 0, m_err = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_sign = 0; m_err = 0; m_ofs = 0; m_tcnt = 0;
        end else begin
            case (m_mode)
                0: if (req) begin
                    m_left = int'(req_steps); m_sign = req_sign; m_err = 0; m_mode = 1;
                end
                1: if (!req) begin
                    if (m_left == 0) m_mode = 0;
                    else if (!locked) begin m_err = 1; m_mode = 0; end
                    else m_mode = 2;
                end
                2: if (locked) begin m_mode = 3; m_tcnt = 0; end
                   else begin m_err = 1; m_mode = 0; end
                default: begin
                    if (!locked) begin m_err = 1; m_mode = 0; end
                    else if (ps_done) begin
                        if (ps_ovf) begin m_err = 1; m_mode = 0; end
                        else begin
                            m_ofs += m_sign ? 1 : -1;
                            m_left--;
                            m_mode = (m_left == 0) ? 0 : 2;
                        end
                    end else if (m_tcnt == TMO - 1) begin m_err = 1; m_mode = 0; end
                    else m_tcnt++;
                end
            endcase
        end
    end

    // Compare all outputs against the model mid-cycle.
    always @(negedge clk) begin
        chk(ack == (m_mode == 1), "R2 ack", ack, m_mode == 1);
        chk(ps_en == (m_mode == 2 && locked), "R3/R4/R5/R8 ps_en", ps_en, m_mode == 2 && locked);
        chk(ps_incdec == m_sign, "R4 ps_incdec", ps_incdec, m_sign);
        chk(busy == (m_mode != 0), "R11 busy", busy, m_mode != 0);
        chk(err == m_err, "R8/R9/R10/R11 err", err, m_err);
        chk($signed(offset) == m_ofs, "R6 offset", $signed(offset), m_ofs);
    end

    // Clock manager model: answers each enable after cm_dly cycles.
    int cm_dly = 2, cm_cnt = 0, cm_phase = 0;
    bit cm_drop = 0, cm_dir = 0;
    always @(posedge clk) begin
        #1;
        ps_done = 0; ps_ovf = 0;
        if (cm_cnt > 0) begin
            cm_cnt--;
            if (cm_cnt == 0) begin
                ps_done = 1;
                if ((cm_dir && cm_phase >= LIM) || (!cm_dir && cm_phase <= -LIM)) ps_ovf = 1;
                else cm_phase += cm_dir ? 1 : -1;
            end
        end
        if (ps_en && !cm_drop) begin cm_cnt = cm_dly; cm_dir = ps_incdec; end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            report();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic run_req(input int steps, input bit sign, input int hold);
        req_steps = CNT_W'(steps); req_sign = sign; req = 1;
        tick(hold);
        req = 0;
        for (int i = 0; i < 3000 && (busy || ack); i++) tick(1);
        tick(3);
    endtask

    initial begin
        tick(3);
        chk(!ack && !ps_en && !busy && !err && offset == 0, "R1 reset state", busy, 0);
        rst_n = 1;
        tick(2);
        // Increment three steps, request held for three cycles.
        run_req(3, 1, 3);
        chk($signed(offset) == 3, "R6 offset after +3", $signed(offset), 3);
        // Decrement five steps with a fast clock manager.
        cm_dly = 1;
        run_req(5, 0, 1);
        chk($signed(offset) == -2, "R6 offset after -5", $signed(offset), -2);
        // Zero steps: acknowledged, no shift, no error.
        run_req(0, 1, 2);
        chk($signed(offset) == -2 && !err, "R7 zero-step request", $signed(offset), -2);
        // Lock low when the request drops: no step, error.
        locked = 0;
        run_req(2, 1, 2);
        chk(err && $signed(offset) == -2, "R8 unlocked start", err, 1);
        locked = 1;
        // Overflow at +LIM: six steps complete, the seventh is rejected.
        cm_dly = 3;
        run_req(10, 1, 2);
        chk(err && $signed(offset) == LIM, "R9 overflow abort", $signed(offset), LIM);
        // A new accepted request clears the error.
        run_req(1, 0, 1);
        chk(!err && $signed(offset) == LIM - 1, "R11 error cleared", err, 0);
        // Lock lost while waiting for done.
        cm_dly = 6;
        req_steps = 4; req_sign = 0; req = 1;
        tick(1); req = 0;
        tick(4); locked = 0;
        tick(3); locked = 1;
        chk(err && !busy, "R8 lock loss mid-sequence", err, 1);
        tick(10);
        // Timeout: clock manager ignores the enable.
        cm_drop = 1;
        run_req(1, 1, 1);
        chk(err && !busy, "R10 timeout", err, 1);
        cm_drop = 0;
        run_req(2, 1, 1);
        chk(!err, "R5 normal after timeout", err, 0);
        report();
    end
endmodule